// File: doc/BRIEF.md
# Set-Associative Victim Way Selector

This block decides which way of a cache set gets overwritten when a lookup misses. It keeps replacement state for every set and offers three policies, chosen at run time by a two-bit policy input. The first is a tree of pseudo-LRU bits. With two ways the single tree bit is exact LRU. The second is a per-set round-robin pointer. The third is the same pointer, except that it steps over the way touched most recently.

A cache controller presents one lookup per cycle on the `acc_*` pins. Each lookup carries the set index, whether it hit, and the hit way. The controller also drives the valid bits of that set's ways. The selector shows the victim for the presented set combinationally. On a strobed miss, that victim is the way being filled. The replacement state of the set changes at the next rising clock edge. All pins are plain control signals: there is no stream handshake, a strobe is always accepted, and back-pressure does not arise.

Top module: `victim_way_sel`

## Requirements
- R1: When any way of the presented set has its valid bit at 0, the victim is the lowest-numbered invalid way, whatever the policy.
- R2: In tree mode each set holds WAYS-1 bits in heap order (node 1 is the root, node n has children 2n and 2n+1). A bit value of 0 steers the victim search toward the lower-numbered half. Every strobed access, hit or miss, rewrites the bits on the path to the touched way so that they point away from it. The touched way is the hit way on a hit and the victim on a miss. With all ways valid, the victim is the leaf reached by following the bits from the root.
- R3: In round-robin mode, with all ways valid, the victim is the set's pointer. In both pointer modes, every strobed miss moves the pointer to one past the way the pointer logic picked, modulo WAYS. This happens even when an invalid way was filled instead.
- R4: In skip mode the pointer's candidate is used unless it equals the set's most-recently-used way, in which case the next way (modulo WAYS) is used. The most-recently-used index is written with the touched way on every strobed access, in every mode.
- R5: A strobed hit never moves the round-robin pointer.
- R6: Reset clears every tree bit, pointer and most-recently-used index to 0. After reset, with all ways valid, the victim is way 0 in tree and round-robin modes and way 1 in skip mode.
- R7: Policy encoding: 2'b00 tree, 2'b01 round-robin, 2'b10 skip, 2'b11 tree.
- R8: An access to one set leaves the victim of every other set unchanged.
- R9: The victim follows the presented set, valid bits and policy in the same cycle. The effect of a strobe on the victim is visible only after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy | input | 2 | Replacement policy select (R7) |
| acc_valid | input | 1 | Lookup strobe |
| acc_set | input | $clog2(SETS) | Set index of the lookup; also selects the set whose victim is shown |
| acc_hit | input | 1 | Lookup hit when 1, miss (fill of the victim) when 0 |
| acc_hit_way | input | $clog2(WAYS) | Way that hit; ignored on a miss |
| way_valid | input | WAYS | Valid bit of each way of the presented set |
| victim_way | output | $clog2(WAYS) | Way to replace in the presented set |

## Verification
The history properties compare the victim in two consecutive cycles. They apply only when the second cycle presents the same set, the same policy and all ways valid. The tests therefore follow each strobe with a plain look at the same set before changing the policy or set. The properties also assume that a hit names a way whose valid bit is 1, and that the valid bits come from the same set as `acc_set`. The directed stimulus only reports hits on resident ways and keeps the valid bits tied to the presented set.

// File: rtl/vsel_pkg.sv
package vsel_pkg;
  typedef enum logic [1:0] {
    POL_TREE     = 2'b00,
    POL_RR       = 2'b01,
    POL_RR_SKIP  = 2'b10,
    POL_TREE_ALT = 2'b11
  } policy_e;
endpackage

// File: rtl/vsel_first_free.sv
module vsel_first_free #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  way_valid,
  output logic             any_free,
  output logic [WAY_W-1:0] free_way
);
  always_comb begin
    any_free = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!way_valid[w]) begin
        any_free = 1'b1;
        free_way = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/vsel_plru.sv
module vsel_plru #(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] sel_set,
  input  logic             touch_en,
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAY_W-1:0] pick_way
);
  // node n of the heap lives at bit n; the root is bit 1
  logic [WAYS-1:1] tree_q [SETS];
  logic [WAYS-1:1] cur_bits;
  logic [WAYS-1:1] nxt_bits;
  logic [WAY_W-1:0] walk_node;
  logic [WAY_W-1:0] upd_node;

  assign cur_bits = tree_q[sel_set];

  // follow the bits from the root down to a leaf
  always_comb begin
    pick_way  = '0;
    walk_node = WAY_W'(1);
    for (int l = 0; l < WAY_W; l++) begin
      pick_way[WAY_W-1-l] = cur_bits[walk_node];
      walk_node = WAY_W'(1 << (l + 1)) | WAY_W'(pick_way >> (WAY_W - 1 - l));
    end
  end

  // point every node on the touched path away from the touched way
  always_comb begin
    nxt_bits = cur_bits;
    upd_node = '0;
    for (int l = 0; l < WAY_W; l++) begin
      upd_node = WAY_W'(1 << l) | WAY_W'(touch_way >> (WAY_W - l));
      nxt_bits[upd_node] = ~touch_way[WAY_W-1-l];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else if (touch_en) begin
      tree_q[sel_set] <= nxt_bits;
    end
  end
endmodule

// File: rtl/vsel_rr.sv
module vsel_rr #(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] sel_set,
  input  logic             skip_mru,
  input  logic             touch_en,
  input  logic [WAY_W-1:0] touch_way,
  input  logic             adv_en,
  output logic [WAY_W-1:0] cand_way
);
  logic [WAY_W-1:0] ptr_q [SETS];
  logic [WAY_W-1:0] mru_q [SETS];
  logic [WAY_W-1:0] ptr_cur;

  assign ptr_cur  = ptr_q[sel_set];
  assign cand_way = (skip_mru && (ptr_cur == mru_q[sel_set])) ? ptr_cur + WAY_W'(1) : ptr_cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        ptr_q[s] <= '0;
        mru_q[s] <= '0;
      end
    end else begin
      if (touch_en) mru_q[sel_set] <= touch_way;
      if (adv_en)   ptr_q[sel_set] <= cand_way + WAY_W'(1);
    end
  end
endmodule

// File: rtl/victim_way_sel.sv
module victim_way_sel
  import vsel_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       policy,
  input  logic             acc_valid,
  input  logic [SET_W-1:0] acc_set,
  input  logic             acc_hit,
  input  logic [WAY_W-1:0] acc_hit_way,
  input  logic [WAYS-1:0]  way_valid,
  output logic [WAY_W-1:0] victim_way
);
  logic             tree_mode;
  logic             skip_mode;
  logic             any_free;
  logic [WAY_W-1:0] free_way;
  logic [WAY_W-1:0] tree_pick;
  logic [WAY_W-1:0] rr_pick;
  logic [WAY_W-1:0] touched;
  logic             rr_adv;

  assign tree_mode = (policy == POL_TREE) || (policy == POL_TREE_ALT);
  assign skip_mode = (policy == POL_RR_SKIP);

  vsel_first_free #(.WAYS(WAYS)) u_free (
    .way_valid (way_valid),
    .any_free  (any_free),
    .free_way  (free_way)
  );

  vsel_plru #(.WAYS(WAYS), .SETS(SETS)) u_tree (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_set   (acc_set),
    .touch_en  (acc_valid),
    .touch_way (touched),
    .pick_way  (tree_pick)
  );

  vsel_rr #(.WAYS(WAYS), .SETS(SETS)) u_rr (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_set   (acc_set),
    .skip_mru  (skip_mode),
    .touch_en  (acc_valid),
    .touch_way (touched),
    .adv_en    (rr_adv),
    .cand_way  (rr_pick)
  );

  always_comb begin
    if (any_free)       victim_way = free_way;
    else if (tree_mode) victim_way = tree_pick;
    else                victim_way = rr_pick;
  end

  assign touched = acc_hit ? acc_hit_way : victim_way;
  assign rr_adv  = acc_valid && !acc_hit && !tree_mode;
endmodule

// File: rtl/victim_way_sel_chk.sv
module victim_way_sel_chk #(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       policy,
  input logic             acc_valid,
  input logic [SET_W-1:0] acc_set,
  input logic             acc_hit,
  input logic [WAY_W-1:0] acc_hit_way,
  input logic [WAYS-1:0]  way_valid,
  input logic [WAY_W-1:0] victim_way
);
  logic             armed;
  logic             full;
  logic             is_tree;
  logic [WAY_W-1:0] touch;
  logic [WAYS-1:0]  below;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assign full    = &way_valid;
  assign is_tree = (policy == 2'b00) || (policy == 2'b11);
  assign touch   = acc_hit ? acc_hit_way : victim_way;
  assign below   = (WAYS'(1) << victim_way) - WAYS'(1);

  assert_free_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !full) |-> (!way_valid[victim_way] && ((way_valid & below) == below)));

  assert_tree_away_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && acc_valid && is_tree) |=>
      (!(acc_set == $past(acc_set) && is_tree && full) || (victim_way != $past(touch))));

  assert_rr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && acc_valid && !acc_hit && policy == 2'b01 && full) |=>
      (!(acc_set == $past(acc_set) && policy == 2'b01 && full) ||
       (victim_way == WAY_W'($past(victim_way) + 1'b1))));

  assert_skip_mru_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && acc_valid) |=>
      (!(acc_set == $past(acc_set) && policy == 2'b10 && full) || (victim_way != $past(touch))));

  assert_hit_holds_ptr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && acc_valid && acc_hit && policy == 2'b01 && full) |=>
      (!(acc_set == $past(acc_set) && policy == 2'b01 && full) || $stable(victim_way)));
endmodule

bind victim_way_sel victim_way_sel_chk #(.WAYS(WAYS), .SETS(SETS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .policy      (policy),
  .acc_valid   (acc_valid),
  .acc_set     (acc_set),
  .acc_hit     (acc_hit),
  .acc_hit_way (acc_hit_way),
  .way_valid   (way_valid),
  .victim_way  (victim_way)
);

// File: tb/sim_victim_way_sel.sv
`timescale 1ns/1ps
module sim_victim_way_sel;
  localparam int WAYS = 4;
  localparam int SETS = 16;
  localparam int WAY_W = $clog2(WAYS);
  localparam int SET_W = $clog2(SETS);
  localparam logic [WAYS-1:0] ALL = '1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       policy = 2'b00;
  logic             acc_valid = 1'b0;
  logic [SET_W-1:0] acc_set = '0;
  logic             acc_hit = 1'b0;
  logic [WAY_W-1:0] acc_hit_way = '0;
  logic [WAYS-1:0]  way_valid = '1;
  logic [WAY_W-1:0] victim_way;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  victim_way_sel #(.WAYS(WAYS), .SETS(SETS)) u0 (
    .clk(clk), .rst_n(rst_n), .policy(policy), .acc_valid(acc_valid),
    .acc_set(acc_set), .acc_hit(acc_hit), .acc_hit_way(acc_hit_way),
    .way_valid(way_valid), .victim_way(victim_way)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: victim actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // present a set without a strobe and compare the victim in the same cycle
  task automatic peek(input int s, input logic [WAYS-1:0] v, input logic [1:0] p,
                      input int exp, input string req);
    @(negedge clk);
    acc_valid = 1'b0;
    acc_set = SET_W'(s);
    way_valid = v;
    policy = p;
    #1;
    check(req, int'(victim_way), exp);
  endtask

  task automatic access(input int s, input logic [WAYS-1:0] v, input logic [1:0] p,
                        input logic hit, input int way);
    @(negedge clk);
    acc_set = SET_W'(s);
    way_valid = v;
    policy = p;
    acc_hit = hit;
    acc_hit_way = WAY_W'(way);
    acc_valid = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0;
    acc_hit = 1'b0;
  endtask

  task automatic t_reset;
    peek(3, ALL, 2'b00, 0, "R6 tree after reset");
    peek(3, ALL, 2'b01, 0, "R6 round-robin after reset");
    peek(3, ALL, 2'b10, 1, "R6 skip after reset");
  endtask

  task automatic t_tree;
    access(1, ALL, 2'b00, 1'b0, 0);
    peek(1, ALL, 2'b00, 2, "R2 R9 tree after miss on way 0");
    access(1, ALL, 2'b00, 1'b0, 0);
    peek(1, ALL, 2'b00, 1, "R2 tree after miss on way 2");
    access(1, ALL, 2'b00, 1'b1, 1);
    peek(1, ALL, 2'b00, 3, "R2 tree after hit on way 1");
    access(1, ALL, 2'b00, 1'b1, 3);
    peek(1, ALL, 2'b00, 0, "R2 tree after hit on way 3");
  endtask

  task automatic t_fifo;
    peek(2, ALL, 2'b01, 0, "R3 round-robin start");
    access(2, ALL, 2'b01, 1'b0, 0);
    peek(2, ALL, 2'b01, 1, "R3 round-robin first step");
    access(2, ALL, 2'b01, 1'b1, 1);
    peek(2, ALL, 2'b01, 1, "R5 hit leaves pointer");
    access(2, ALL, 2'b01, 1'b0, 0);
    access(2, ALL, 2'b01, 1'b0, 0);
    peek(2, ALL, 2'b01, 3, "R3 round-robin third step");
    access(2, ALL, 2'b01, 1'b0, 0);
    peek(2, ALL, 2'b01, 0, "R3 round-robin wrap");
  endtask

  task automatic t_skip;
    peek(4, ALL, 2'b10, 1, "R4 skip initial");
    access(4, ALL, 2'b10, 1'b1, 2);
    peek(4, ALL, 2'b10, 0, "R4 skip after hit on way 2");
    access(4, ALL, 2'b10, 1'b0, 0);
    peek(4, ALL, 2'b10, 1, "R4 skip after fill of way 0");
    access(4, ALL, 2'b10, 1'b1, 1);
    peek(4, ALL, 2'b10, 2, "R4 skip steps over way 1");
    access(4, ALL, 2'b10, 1'b0, 0);
    peek(4, ALL, 2'b10, 3, "R4 skip pointer moved past pick");
  endtask

  task automatic t_invalid;
    peek(5, 4'b1011, 2'b00, 2, "R1 tree lowest invalid");
    peek(5, 4'b0000, 2'b10, 0, "R1 all invalid");
    peek(5, 4'b0111, 2'b01, 3, "R1 only top invalid");
    peek(6, 4'b1101, 2'b01, 1, "R1 round-robin invalid override");
    access(6, 4'b1101, 2'b01, 1'b0, 0);
    peek(6, ALL, 2'b01, 1, "R3 pointer advances on invalid fill");
  endtask

  task automatic t_alias;
    peek(7, ALL, 2'b11, 0, "R7 code 11 initial");
    access(7, ALL, 2'b11, 1'b0, 0);
    peek(7, ALL, 2'b11, 2, "R7 code 11 acts as tree");
  endtask

  task automatic t_isolation;
    access(9, ALL, 2'b00, 1'b0, 0);
    access(9, ALL, 2'b01, 1'b0, 0);
    peek(10, ALL, 2'b00, 0, "R8 neighbour tree untouched");
    peek(10, ALL, 2'b01, 0, "R8 neighbour pointer untouched");
    peek(9, ALL, 2'b01, 1, "R8 accessed set pointer moved");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_tree();
    t_fifo();
    t_skip();
    t_invalid();
    t_alias();
    t_isolation();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule